// File: doc/BRIEF.md
# PLL Coarse Frequency Lock Detector

This block decides whether a PLL's oscillator is running close enough to its target frequency to count as coarsely locked. A measurement window lasts a fixed number of reference-clock cycles (32 by default). During each window the block counts oscillator edges and compares the total with the expected figure, which is the window length times the programmed multiplication factor. If the count lies within ten percent of that figure in either direction, the lock output goes high. Otherwise it goes low.

The oscillator count runs in the oscillator's own clock domain as a Gray-coded free-running counter. A two-flop synchronizer carries it into the reference domain. At the end of each window the reference side subtracts the previous snapshot from the current one, so it never has to stop or reset the fast counter. A sticky status bit records a loss of lock that follows a confirmed lock, and a one-cycle clear strobe resets it. Writing a new multiplication factor restarts the measurement.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is asserted, and after it until the first evaluation, `lockOut` and `unlockSticky` are both 0.
- R2: `lockOut` changes only at the end of a measurement window of WIN_CYC reference cycles (32 by default). It stays 0 until one full window after reset has been evaluated.
- R3: At a window end, `lockOut` becomes 1 exactly when the oscillator edge count N satisfies 10·N ≥ 9·E and 10·N ≤ 11·E, where E = WIN_CYC × `mulFactor`. This is the ±10 % window with its bounds rounded inward.
- R4: `unlockSticky` sets at the end of a window that fails R3, provided that a window has passed since the last reset or factor change.
- R5: Once set, `unlockSticky` stays 1 until a cycle with `clrStatus` high clears it. If a set and a clear occur in the same cycle, the set wins.
- R6: A change of `mulFactor` restarts the window, drops `lockOut` on that same reference edge, and forgets any earlier lock. Failing windows that come before the next passing window then leave `unlockSticky` at 0.
- R7: The oscillator count reaches the reference domain as a Gray code whose value changes by at most one bit per oscillator cycle. Counts stay exact when the oscillator runs well above the reference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| refClk | input | 1 | Reference (phase-detector input) clock |
| vcoClk | input | 1 | Oscillator clock being measured |
| rstN | input | 1 | Active-low asynchronous reset, shared by both domains |
| mulFactor | input | MUL_W | Loop multiplication factor, synchronous to refClk |
| clrStatus | input | 1 | One-cycle strobe that clears the sticky status |
| lockOut | output | 1 | Coarse frequency lock, refreshed once per window |
| unlockSticky | output | 1 | Sticky loss-of-lock status |

## Verification
The bench uses the default parameters: a 32-cycle window and a 6-bit factor. It runs the oscillator at factors of 8 and 20, which is 20 times the reference clock. That puts wide Gray-count increments per reference cycle within reach. The oscillator is driven at 0.8×, 0.95×, 1.05×, 1.2× and 2.5× of target, so passing and failing windows occur on both sides of the tolerance band. Factor changes made while locked and while failing show whether the lock history is forgotten.

// File: rtl/flm_pkg.sv
package flm_pkg;
  // Strobes from the window control to the datapath
  typedef struct packed {
    logic winEnd;   // last reference cycle of a measurement window
    logic restart;  // factor changed: begin a fresh window
  } flm_ctrl_t;
endpackage

// File: rtl/flm_vco_counter.sv
module flm_vco_counter #(
  parameter int CNT_W = 13
) (
  input  logic             vcoClk,
  input  logic             rstN,
  output logic [CNT_W-1:0] grayOut
);
  logic rstSync1, vcoRstN;
  logic [CNT_W-1:0] binQ;
  logic [CNT_W-1:0] binNext;

  // Reset released synchronously to the oscillator clock
  always_ff @(posedge vcoClk or negedge rstN) begin
    if (!rstN) begin
      rstSync1 <= 1'b0;
      vcoRstN  <= 1'b0;
    end else begin
      rstSync1 <= 1'b1;
      vcoRstN  <= rstSync1;
    end
  end

  assign binNext = binQ + CNT_W'(1);

  always_ff @(posedge vcoClk or negedge vcoRstN) begin
    if (!vcoRstN) begin
      binQ    <= '0;
      grayOut <= '0;
    end else begin
      binQ    <= binNext;
      grayOut <= binNext ^ (binNext >> 1);
    end
  end

  // R7: only one bit of the crossing code moves per oscillator cycle
  a_r7_gray_one_bit: assert property (@(posedge vcoClk) disable iff (!vcoRstN)
    $countones(grayOut ^ $past(grayOut)) <= 1);
endmodule

// File: rtl/flm_ctrl.sv
module flm_ctrl
  import flm_pkg::*;
#(
  parameter int WIN_CYC = 32,
  parameter int MUL_W   = 6
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [MUL_W-1:0] mulFactor,
  output flm_ctrl_t        ctrl
);
  localparam int WIN_W = $clog2(WIN_CYC);

  logic [WIN_W-1:0] winCnt;
  logic [MUL_W-1:0] mulQ;

  assign ctrl.restart = (mulFactor != mulQ);
  assign ctrl.winEnd  = (winCnt == WIN_W'(WIN_CYC - 1)) && !ctrl.restart;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      mulQ   <= '0;
    end else begin
      mulQ <= mulFactor;
      if (ctrl.restart || ctrl.winEnd) winCnt <= '0;
      else                              winCnt <= winCnt + WIN_W'(1);
    end
  end

  // R6: a factor change always starts the window from its first cycle
  a_r6_restart_zeroes: assert property (@(posedge refClk) disable iff (!rstN)
    ctrl.restart |=> (winCnt == '0));
  // R2: window end and restart never coincide
  a_r2_end_excl: assert property (@(posedge refClk) disable iff (!rstN)
    !(ctrl.winEnd && ctrl.restart));
endmodule

// File: rtl/flm_datapath.sv
module flm_datapath
  import flm_pkg::*;
#(
  parameter int WIN_CYC = 32,
  parameter int MUL_W   = 6,
  parameter int CNT_W   = 13
) (
  input  logic             refClk,
  input  logic             rstN,
  input  flm_ctrl_t        ctrl,
  input  logic [MUL_W-1:0] mulFactor,
  input  logic [CNT_W-1:0] vcoGray,
  input  logic             clrStatus,
  output logic             lockOut,
  output logic             unlockSticky
);
  localparam int PW = CNT_W + 4;

  function automatic logic [CNT_W-1:0] grayToBin(input logic [CNT_W-1:0] g);
    logic [CNT_W-1:0] b;
    b[CNT_W-1] = g[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [CNT_W-1:0] graySync1, graySync2, prevBin, syncBin, winCount;
  logic [PW-1:0]    expCnt, cnt10, lo9, hi11;
  logic             inWin, lockSeen, failSet;

  assign syncBin  = grayToBin(graySync2);
  assign winCount = syncBin - prevBin;
  assign expCnt   = PW'(WIN_CYC) * PW'(mulFactor);
  assign cnt10    = PW'(winCount) * PW'(10);
  assign lo9      = expCnt * PW'(9);
  assign hi11     = expCnt * PW'(11);
  assign inWin    = (cnt10 >= lo9) && (cnt10 <= hi11);
  assign failSet  = ctrl.winEnd && !inWin && lockSeen;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      graySync1    <= '0;
      graySync2    <= '0;
      prevBin      <= '0;
      lockOut      <= 1'b0;
      lockSeen     <= 1'b0;
      unlockSticky <= 1'b0;
    end else begin
      graySync1 <= vcoGray;
      graySync2 <= graySync1;
      if (ctrl.restart) begin
        prevBin  <= syncBin;
        lockOut  <= 1'b0;
        lockSeen <= 1'b0;
      end else if (ctrl.winEnd) begin
        prevBin <= syncBin;
        lockOut <= inWin;
        if (inWin) lockSeen <= 1'b1;
      end
      if (failSet)        unlockSticky <= 1'b1;
      else if (clrStatus) unlockSticky <= 1'b0;
    end
  end

  // R2: lock moves only on a window end or a restart
  a_r2_lock_only_at_end: assert property (@(posedge refClk) disable iff (!rstN)
    !(ctrl.winEnd || ctrl.restart) |=> $stable(lockOut));
  // R6: a restart drops the lock on the same edge
  a_r6_restart_drops: assert property (@(posedge refClk) disable iff (!rstN)
    ctrl.restart |=> !lockOut);
  // R5: the status holds until a clear strobe
  a_r5_sticky_holds: assert property (@(posedge refClk) disable iff (!rstN)
    (unlockSticky && !clrStatus) |=> unlockSticky);
  // R4: the status can only rise together with a failed window
  a_r4_sticky_on_fail: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(unlockSticky) |-> !lockOut);
endmodule

// File: rtl/freq_lock_monitor.sv
module freq_lock_monitor
  import flm_pkg::*;
#(
  parameter int WIN_CYC = 32,
  parameter int MUL_W   = 6
) (
  input  logic             refClk,
  input  logic             vcoClk,
  input  logic             rstN,
  input  logic [MUL_W-1:0] mulFactor,
  input  logic             clrStatus,
  output logic             lockOut,
  output logic             unlockSticky
);
  // Count headroom: four times the largest expected window count
  localparam int CNT_W = $clog2(WIN_CYC) + MUL_W + 2;

  flm_ctrl_t        ctrl;
  logic [CNT_W-1:0] vcoGray;

  flm_vco_counter #(.CNT_W(CNT_W)) u_vco (
    .vcoClk (vcoClk),
    .rstN   (rstN),
    .grayOut(vcoGray)
  );

  flm_ctrl #(.WIN_CYC(WIN_CYC), .MUL_W(MUL_W)) u_ctrl (
    .refClk   (refClk),
    .rstN     (rstN),
    .mulFactor(mulFactor),
    .ctrl     (ctrl)
  );

  flm_datapath #(.WIN_CYC(WIN_CYC), .MUL_W(MUL_W), .CNT_W(CNT_W)) u_dp (
    .refClk      (refClk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .mulFactor   (mulFactor),
    .vcoGray     (vcoGray),
    .clrStatus   (clrStatus),
    .lockOut     (lockOut),
    .unlockSticky(unlockSticky)
  );
endmodule

// File: tb/freq_lock_monitor_tb.sv
`timescale 1ns/1ps
module freq_lock_monitor_tb;
  localparam real REF_PERIOD = 320.0;
  localparam int  WIN        = 32;

  logic refClk = 1'b0, vcoClk = 1'b0, rstN = 1'b0, clrStatus = 1'b0;
  logic [5:0] mulFactor = 6'd8;
  logic lockOut, unlockSticky;
  real  vcoHalf = REF_PERIOD / 16.0;

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct {
    logic  lock;
    logic  sticky;
    string tag;
  } exp_t;
  exp_t sbQ[$];

  freq_lock_monitor u_dut (
    .refClk(refClk), .vcoClk(vcoClk), .rstN(rstN), .mulFactor(mulFactor),
    .clrStatus(clrStatus), .lockOut(lockOut), .unlockSticky(unlockSticky)
  );

  initial forever #(REF_PERIOD / 2.0) refClk = ~refClk;
  initial forever #(vcoHalf) vcoClk = ~vcoClk;

  // Oscillator at mul * ratio times the reference frequency
  task automatic setVco(input int mul, input real ratio);
    vcoHalf = REF_PERIOD / (mul * ratio) / 2.0;
  endtask

  task automatic waitRef(input int n);
    repeat (n) @(posedge refClk);
    @(negedge refClk);
  endtask

  // Driver: push expectation, wait for the monitor to consume it
  task automatic expectOut(input logic l, input logic s, input string tag);
    exp_t e;
    e.lock = l; e.sticky = s; e.tag = tag;
    sbQ.push_back(e);
    wait (sbQ.size() == 0);
    @(negedge refClk);
  endtask

  task automatic pulseClr();
    clrStatus = 1'b1;
    @(negedge refClk);
    clrStatus = 1'b0;
  endtask

  // Monitor: compare outputs away from the active edge
  initial forever begin
    exp_t e;
    wait (sbQ.size() > 0);
    @(negedge refClk);
    e = sbQ.pop_front();
    checks++;
    if (lockOut !== e.lock) begin
      errors++;
      $display("FAIL %s lockOut actual=%b expected=%b", e.tag, lockOut, e.lock);
    end
    checks++;
    if (unlockSticky !== e.sticky) begin
      errors++;
      $display("FAIL %s unlockSticky actual=%b expected=%b", e.tag, unlockSticky, e.sticky);
    end
  end

  initial begin
    setVco(8, 1.0);
    waitRef(3);
    expectOut(1'b0, 1'b0, "R1 in reset");
    rstN = 1'b1;
    waitRef(20);
    expectOut(1'b0, 1'b0, "R2 before first window");
    waitRef(3 * WIN);
    expectOut(1'b1, 1'b0, "R3 on target x8");
    setVco(8, 1.2);
    waitRef(3 * WIN);
    expectOut(1'b0, 1'b1, "R4 fast by 20%");
    setVco(8, 1.0);
    waitRef(3 * WIN);
    expectOut(1'b1, 1'b1, "R5 sticky holds after relock");
    pulseClr();
    expectOut(1'b1, 1'b0, "R5 cleared by strobe");
    // Factor change to 20 with a matching oscillator
    mulFactor = 6'd20; setVco(20, 1.0);
    @(negedge refClk);
    expectOut(1'b0, 1'b0, "R6 restart drops lock");
    waitRef(3 * WIN);
    expectOut(1'b1, 1'b0, "R7 x20 count exact");
    // Back to 8 while the oscillator stays 20x: history is forgotten
    mulFactor = 6'd8;
    @(negedge refClk);
    expectOut(1'b0, 1'b0, "R6 restart from lock");
    waitRef(3 * WIN);
    expectOut(1'b0, 1'b0, "R6 no sticky before relock");
    setVco(8, 1.0);
    waitRef(3 * WIN);
    expectOut(1'b1, 1'b0, "R3 relock x8");
    setVco(8, 0.8);
    waitRef(3 * WIN);
    expectOut(1'b0, 1'b1, "R4 slow by 20%");
    setVco(8, 1.05);
    waitRef(3 * WIN);
    pulseClr();
    expectOut(1'b1, 1'b0, "R3 fast by 5%");
    setVco(8, 0.95);
    waitRef(3 * WIN);
    expectOut(1'b1, 1'b0, "R3 slow by 5%");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge refClk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule